// File: doc/BRIEF.md
# Banked work RAM address decoder

This block sits between an 8-bit CPU core and the memories of a handheld-console style 16-bit address space. It decodes every CPU read and write. It steers work RAM traffic to a 32 KB work RAM that is organised as eight 4 KB banks. The lower 4 KB work RAM window is tied to bank 0. The upper 4 KB window follows a bank-select register. A third window echoes the lower one. While the boot phase lasts, a boot ROM overlays part of the low address space. A single write to a boot-off register ends that phase for good. A 127-byte high RAM is kept inside the block.

Cartridge ROM, video RAM, external RAM and the remaining I/O are not handled here. Traffic for those ranges leaves the block on a plain external request port. The work RAM and the boot ROM are reached through asynchronous-read ports. The block samples the selected source into a registered read-data output, which gives every read one cycle of latency. A mode input selects a monochrome mode. In that mode the upper window is fixed to bank 1 and the bank-select register cannot be written.

Top module: `membank_decoder`

## Requirements
- R1: After reset, the bank-select register holds 1 and the boot overlay is active. `rd_valid` is low. A read of 0xFF70 returns 0xF9.
- R2: An access to 0xC000–0xCFFF goes to the work RAM port. The work RAM offset is address[11:0], which lies in bank 0.
- R3: In colour mode (`mono_mode`=0), an access to 0xD000–0xDFFF goes to the work RAM port. The work RAM offset is bank×0x1000 + address[11:0].
- R4: A write to 0xFF70 sets the bank to data[2:0], and a value of 0 selects bank 1. The upper data bits have no effect. A read of 0xFF70 returns {5'b11111, bank}.
- R5: With `mono_mode`=1, the upper window uses bank 1 whatever the stored bank is. Writes to 0xFF70 are ignored, so the stored value is unchanged once `mono_mode` returns to 0.
- R6: A read or write of 0xE000–0xEFFF goes to the work RAM at offset address & 0x1FFF, which is the bank 0 range.
- R7: While boot is active, reads of 0x0000–0x00FF and 0x0200–0x08FF are served by the boot ROM port, with `boot_addr` = address[11:0]. Reads of 0x0100–0x01FF and of 0x0900 upwards go to the external port. Writes in this range always go to the external port.
- R8: A write of any value to 0xFF50 ends the boot phase until the next reset, after which low addresses read from the external port. The write itself is not forwarded.
- R9: An access to 0xFF80–0xFFFE uses the internal high RAM at index address & 0x7F. A read returns the last value written to that index.
- R10: An access outside the work RAM windows, high RAM, 0xFF70, the boot overlay and 0xFF50 writes is forwarded. A read raises `ext_re`, and a write raises `ext_we` with `ext_addr` and `ext_wdata`. Internally handled ranges never raise `ext_re` or `ext_we`.
- R11: A read (`cpu_re`=1, `cpu_we`=0) gives `rd_valid`=1 with its data exactly one cycle later. A write gives no `rd_valid`. When both strobes are high, the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mono_mode | input | 1 | 1 = monochrome mode: upper bank fixed, bank register locked |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_re | input | 1 | CPU read strobe |
| cpu_we | input | 1 | CPU write strobe (wins over read) |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| wram_addr | output | 15 | Work RAM byte offset |
| wram_wdata | output | 8 | Work RAM write data |
| wram_re | output | 1 | Work RAM read |
| wram_we | output | 1 | Work RAM write |
| wram_rdata | input | 8 | Work RAM asynchronous read data |
| boot_addr | output | 12 | Boot ROM byte offset |
| boot_re | output | 1 | Boot ROM read |
| boot_rdata | input | 8 | Boot ROM asynchronous read data |
| ext_addr | output | 16 | Forwarded address |
| ext_wdata | output | 8 | Forwarded write data |
| ext_re | output | 1 | Forwarded read |
| ext_we | output | 1 | Forwarded write |
| ext_rdata | input | 8 | External asynchronous read data |

## Verification
The external work RAM, boot ROM and request port are modelled as address-derived patterns that differ from one another. A returned byte therefore shows which source served it and at which offset. Strided sweeps cover the lower window, the echo window and the upper window under every bank value 0 to 7, with junk in the upper data bits. These sweeps separate a correct offset from a missing bank term, a missing zero-to-one fixup and a mis-decoded echo. A sweep of the low 2.75 KB before and after the boot-off write shows the overlay limits, the 0x0100–0x01FF hole and the end of the overlay. Full write/read passes over high RAM, forwarded writes to several unmapped regions, a monochrome-mode pass and a combined read/write strobe round this out.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    localparam int WIN_OFF_W = 12;

    localparam logic [3:0]  WIN_LOW   = 4'hC;
    localparam logic [3:0]  WIN_UPPER = 4'hD;
    localparam logic [3:0]  WIN_ECHO  = 4'hE;
    localparam logic [15:0] BANK_REG  = 16'hFF70;
    localparam logic [15:0] BOOT_OFF  = 16'hFF50;
    localparam logic [15:0] HRAM_BASE = 16'hFF80;
    localparam logic [7:0]  BOOT_HOLE = 8'h01;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_WRAM,
        SRC_BOOT,
        SRC_HRAM,
        SRC_BANK,
        SRC_EXT
    } src_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } rsp_t;

endpackage

// File: rtl/mbd_route.sv
module mbd_route #(
    parameter int BANK_SEL_W = 3,
    parameter int WRAM_AW    = 15,
    parameter int HRAM_BYTES = 127,
    parameter int HRAM_IW    = 7,
    parameter int BOOT_BYTES = 2304
) (
    input  logic [15:0]           addr,
    input  logic                  re,
    input  logic                  we,
    input  logic                  boot_on,
    input  logic [BANK_SEL_W-1:0] bank_sel,
    output mbd_pkg::src_e         src,
    output logic [WRAM_AW-1:0]    wram_off,
    output logic [HRAM_IW-1:0]    hram_idx,
    output logic                  bank_wr,
    output logic                  boot_clr
);
    import mbd_pkg::*;

    localparam logic [16:0] BOOT_END = 17'(BOOT_BYTES);
    localparam logic [16:0] HRAM_END = 17'(32'(HRAM_BASE) + HRAM_BYTES);

    logic [3:0] nib;
    logic       acc;
    logic       in_wram;
    logic       in_boot;
    logic       in_hram;

    always_comb begin
        nib      = addr[15:12];
        acc      = re | we;
        in_wram  = (nib == WIN_LOW) || (nib == WIN_UPPER) || (nib == WIN_ECHO);
        in_boot  = boot_on && ({1'b0, addr} < BOOT_END) && (addr[15:8] != BOOT_HOLE);
        in_hram  = (addr >= HRAM_BASE) && ({1'b0, addr} < HRAM_END);
        hram_idx = addr[HRAM_IW-1:0];
        bank_wr  = we && (addr == BANK_REG);
        boot_clr = we && (addr == BOOT_OFF);

        if (nib == WIN_UPPER) begin
            wram_off = {bank_sel, addr[WIN_OFF_W-1:0]};
        end else begin
            wram_off = {{BANK_SEL_W{1'b0}}, addr[WIN_OFF_W-1:0]};
        end

        if (!acc) begin
            src = SRC_NONE;
        end else if (in_wram) begin
            src = SRC_WRAM;
        end else if (addr == BANK_REG) begin
            src = SRC_BANK;
        end else if (boot_clr) begin
            src = SRC_NONE;
        end else if (in_hram) begin
            src = SRC_HRAM;
        end else if (in_boot && !we) begin
            src = SRC_BOOT;
        end else begin
            src = SRC_EXT;
        end
    end

endmodule

// File: rtl/mbd_ctrl.sv
module mbd_ctrl #(
    parameter int BANK_SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mono_mode,
    input  logic                  bank_wr,
    input  logic [BANK_SEL_W-1:0] bank_wdata,
    input  logic                  boot_clr,
    output logic [BANK_SEL_W-1:0] bank_q,
    output logic [BANK_SEL_W-1:0] bank_eff,
    output logic                  boot_on
);
    localparam logic [BANK_SEL_W-1:0] BANK_ONE = BANK_SEL_W'(1);

    typedef struct packed {
        logic [BANK_SEL_W-1:0] bank;
        logic                  boot;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bank_wr && !mono_mode) begin
            st_d.bank = (bank_wdata == '0) ? BANK_ONE : bank_wdata;
        end
        if (boot_clr) begin
            st_d.boot = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bank <= BANK_ONE;
            st_q.boot <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_q   = st_q.bank;
    assign bank_eff = mono_mode ? BANK_ONE : st_q.bank;
    assign boot_on  = st_q.boot;

endmodule

// File: rtl/mbd_hram.sv
module mbd_hram #(
    parameter int HRAM_BYTES = 127,
    parameter int HRAM_IW    = 7
) (
    input  logic               clk,
    input  logic               we,
    input  logic [HRAM_IW-1:0] idx,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata
);
    logic [7:0] mem_q [HRAM_BYTES];
    logic       hit;

    always_comb begin
        hit   = (32'(idx) < HRAM_BYTES);
        rdata = hit ? mem_q[idx] : 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (we && hit) begin
            mem_q[idx] <= wdata;
        end
    end

endmodule

// File: rtl/membank_decoder.sv
module membank_decoder #(
    parameter int BANK_CNT   = 8,
    parameter int HRAM_BYTES = 127,
    parameter int BOOT_BYTES = 2304
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mono_mode,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_re,
    input  logic        cpu_we,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic [14:0] wram_addr,
    output logic [7:0]  wram_wdata,
    output logic        wram_re,
    output logic        wram_we,
    input  logic [7:0]  wram_rdata,
    output logic [11:0] boot_addr,
    output logic        boot_re,
    input  logic [7:0]  boot_rdata,
    output logic [15:0] ext_addr,
    output logic [7:0]  ext_wdata,
    output logic        ext_re,
    output logic        ext_we,
    input  logic [7:0]  ext_rdata
);
    import mbd_pkg::*;

    localparam int BANK_SEL_W = $clog2(BANK_CNT);
    localparam int WRAM_AW    = BANK_SEL_W + WIN_OFF_W;
    localparam int HRAM_IW    = $clog2(HRAM_BYTES + 1);

    src_e                  src;
    logic [WRAM_AW-1:0]    wram_off;
    logic [HRAM_IW-1:0]    hram_idx;
    logic                  bank_wr;
    logic                  boot_clr;
    logic [BANK_SEL_W-1:0] bank_q;
    logic [BANK_SEL_W-1:0] bank_eff;
    logic                  boot_on;
    logic [7:0]            hram_rdata;
    logic                  rd_req;

    assign rd_req = cpu_re && !cpu_we;

    mbd_route #(
        .BANK_SEL_W (BANK_SEL_W),
        .WRAM_AW    (WRAM_AW),
        .HRAM_BYTES (HRAM_BYTES),
        .HRAM_IW    (HRAM_IW),
        .BOOT_BYTES (BOOT_BYTES)
    ) u_route (
        .addr     (cpu_addr),
        .re       (cpu_re),
        .we       (cpu_we),
        .boot_on  (boot_on),
        .bank_sel (bank_eff),
        .src      (src),
        .wram_off (wram_off),
        .hram_idx (hram_idx),
        .bank_wr  (bank_wr),
        .boot_clr (boot_clr)
    );

    mbd_ctrl #(
        .BANK_SEL_W (BANK_SEL_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mono_mode  (mono_mode),
        .bank_wr    (bank_wr),
        .bank_wdata (cpu_wdata[BANK_SEL_W-1:0]),
        .boot_clr   (boot_clr),
        .bank_q     (bank_q),
        .bank_eff   (bank_eff),
        .boot_on    (boot_on)
    );

    mbd_hram #(
        .HRAM_BYTES (HRAM_BYTES),
        .HRAM_IW    (HRAM_IW)
    ) u_hram (
        .clk   (clk),
        .we    (cpu_we && (src == SRC_HRAM)),
        .idx   (hram_idx),
        .wdata (cpu_wdata),
        .rdata (hram_rdata)
    );

    always_comb begin
        wram_addr  = 15'(wram_off);
        wram_wdata = cpu_wdata;
        wram_re    = rd_req && (src == SRC_WRAM);
        wram_we    = cpu_we && (src == SRC_WRAM);
        boot_addr  = cpu_addr[11:0];
        boot_re    = (src == SRC_BOOT);
        ext_addr   = cpu_addr;
        ext_wdata  = cpu_wdata;
        ext_re     = rd_req && (src == SRC_EXT);
        ext_we     = cpu_we && (src == SRC_EXT);
    end

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d.valid = rd_req;
        unique case (src)
            SRC_WRAM: rsp_d.data = wram_rdata;
            SRC_BOOT: rsp_d.data = boot_rdata;
            SRC_HRAM: rsp_d.data = hram_rdata;
            SRC_BANK: rsp_d.data = {{(8-BANK_SEL_W){1'b1}}, bank_q};
            SRC_EXT:  rsp_d.data = ext_rdata;
            default:  rsp_d.data = 8'hFF;
        endcase
        if (!rd_req) begin
            rsp_d.data = rsp_q.data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q.valid <= 1'b0;
            rsp_q.data  <= 8'h00;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_data  = rsp_q.data;
    assign rd_valid = rsp_q.valid;

endmodule

// File: rtl/membank_decoder_chk.sv
module membank_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mono_mode,
    input logic [15:0] cpu_addr,
    input logic        cpu_re,
    input logic        cpu_we,
    input logic        rd_valid,
    input logic [14:0] wram_addr,
    input logic        wram_re,
    input logic        wram_we,
    input logic        boot_re,
    input logic        ext_re,
    input logic        ext_we
);
    logic wram_acc;
    logic internal_rng;

    assign wram_acc     = wram_re || wram_we;
    assign internal_rng = (cpu_addr[15:12] == 4'hC) || (cpu_addr[15:12] == 4'hD) ||
                          (cpu_addr[15:12] == 4'hE) ||
                          ((cpu_addr >= 16'hFF80) && (cpu_addr <= 16'hFFFE));

    // R11
    read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && !cpu_we) |=> rd_valid);

    // R11
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_re && !cpu_we) |=> !rd_valid);

    // R2
    low_window_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wram_acc && cpu_addr[15:12] == 4'hC) |-> (wram_addr[14:12] == 3'd0));

    // R3
    upper_never_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wram_acc && cpu_addr[15:12] == 4'hD) |-> (wram_addr[14:12] != 3'd0));

    // R5
    mono_upper_bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mono_mode && wram_acc && cpu_addr[15:12] == 4'hD) |-> (wram_addr[14:12] == 3'd1));

    // R10
    internal_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_re || cpu_we) && internal_rng) |-> (!ext_re && !ext_we));

    // R10
    ext_write_needs_cpu_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_we |-> cpu_we);

    // R8
    boot_off_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 16'hFF50) |=> !boot_re);

endmodule

bind membank_decoder membank_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mono_mode (mono_mode),
    .cpu_addr  (cpu_addr),
    .cpu_re    (cpu_re),
    .cpu_we    (cpu_we),
    .rd_valid  (rd_valid),
    .wram_addr (wram_addr),
    .wram_re   (wram_re),
    .wram_we   (wram_we),
    .boot_re   (boot_re),
    .ext_re    (ext_re),
    .ext_we    (ext_we)
);

// File: tb/membank_decoder_test.sv
module membank_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mono_mode = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_re = 1'b0;
    logic        cpu_we = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [14:0] wram_addr;
    logic [7:0]  wram_wdata;
    logic        wram_re;
    logic        wram_we;
    logic [7:0]  wram_rdata;
    logic [11:0] boot_addr;
    logic        boot_re;
    logic [7:0]  boot_rdata;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic        ext_re;
    logic        ext_we;
    logic [7:0]  ext_rdata;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] wpat(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction
    function automatic logic [7:0] bpat(input logic [11:0] a);
        return a[7:0] ^ {4'h0, a[11:8]} ^ 8'hC3;
    endfunction
    function automatic logic [7:0] epat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h96;
    endfunction

    assign wram_rdata = wpat(wram_addr);
    assign boot_rdata = bpat(boot_addr);
    assign ext_rdata  = epat(ext_addr);

    membank_decoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mono_mode  (mono_mode),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_re     (cpu_re),
        .cpu_we     (cpu_we),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .wram_addr  (wram_addr),
        .wram_wdata (wram_wdata),
        .wram_re    (wram_re),
        .wram_we    (wram_we),
        .wram_rdata (wram_rdata),
        .boot_addr  (boot_addr),
        .boot_re    (boot_re),
        .boot_rdata (boot_rdata),
        .ext_addr   (ext_addr),
        .ext_wdata  (ext_wdata),
        .ext_re     (ext_re),
        .ext_we     (ext_we),
        .ext_rdata  (ext_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // read: captures routing during the request cycle, data one cycle later
    task automatic rd(input logic [15:0] a, output logic [7:0] d,
                      output logic w, output logic b, output logic e, output logic [14:0] wa);
        @(negedge clk);
        cpu_addr = a; cpu_re = 1'b1; cpu_we = 1'b0;
        #1;
        w = wram_re; b = boot_re; e = ext_re; wa = wram_addr;
        @(posedge clk);
        @(negedge clk);
        chk(rd_valid === 1'b1, "R11 valid after read", 32'(rd_valid), 32'd1);
        d = rd_data;
        cpu_re = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] v,
                      output logic w, output logic e, output logic [14:0] wa);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = v; cpu_we = 1'b1; cpu_re = 1'b0;
        #1;
        w = wram_we; e = ext_we; wa = wram_addr;
        @(posedge clk);
        @(negedge clk);
        chk(rd_valid === 1'b0, "R11 no valid after write", 32'(rd_valid), 32'd0);
        cpu_we = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic        w, b, e;
        logic [14:0] wa;
        logic [2:0]  eb;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(rd_valid === 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        rd(16'hFF70, d, w, b, e, wa);
        chk(d === 8'hF9, "R1 bank readback", 32'(d), 32'hF9);
        rd(16'h0050, d, w, b, e, wa);
        chk(b === 1'b1 && d === bpat(12'h050), "R1 boot active", 32'(d), 32'(bpat(12'h050)));

        // R7 boot overlay sweep
        for (int a = 0; a < 16'h0B00; a += 16'h11) begin
            bit exp_boot;
            exp_boot = (a < 2304) && (a[15:8] != 8'h01);
            rd(16'(a), d, w, b, e, wa);
            if (exp_boot)
                chk(b === 1'b1 && e === 1'b0 && d === bpat(12'(a)), "R7 boot read", 32'(d), 32'(bpat(12'(a))));
            else
                chk(b === 1'b0 && e === 1'b1 && d === epat(16'(a)), "R7 cart read", 32'(d), 32'(epat(16'(a))));
        end
        wr(16'h0040, 8'h77, w, e, wa);
        chk(e === 1'b1 && ext_wdata === 8'h77 && ext_addr === 16'h0040, "R7 boot range write forwarded", 32'(e), 32'd1);

        // R10 forwarding of unmapped regions
        begin
            logic [15:0] fwd [7] = '{16'h4000, 16'h7FFF, 16'h8123, 16'hA456, 16'hF000, 16'hFF00, 16'hFFFF};
            foreach (fwd[i]) begin
                rd(fwd[i], d, w, b, e, wa);
                chk(e === 1'b1 && w === 1'b0 && d === epat(fwd[i]), "R10 ext read", 32'(d), 32'(epat(fwd[i])));
                @(negedge clk);
                cpu_addr = fwd[i]; cpu_wdata = 8'(i * 37 + 5); cpu_we = 1'b1;
                #1;
                chk(ext_we === 1'b1 && ext_addr === fwd[i] && ext_wdata === 8'(i * 37 + 5),
                    "R10 ext write", {ext_we, 7'd0, ext_wdata, ext_addr}, {8'h80, 8'(i * 37 + 5), fwd[i]});
                @(posedge clk);
                @(negedge clk);
                cpu_we = 1'b0;
            end
        end
        rd(16'hFF50, d, w, b, e, wa);
        chk(e === 1'b1 && d === epat(16'hFF50), "R10 boot-off reg read forwarded", 32'(d), 32'(epat(16'hFF50)));

        // R8 end of boot phase
        wr(16'hFF50, 8'h00, w, e, wa);
        chk(e === 1'b0, "R8 boot-off write not forwarded", 32'(e), 32'd0);
        for (int a = 0; a < 16'h0900; a += 16'h67) begin
            rd(16'(a), d, w, b, e, wa);
            chk(b === 1'b0 && e === 1'b1 && d === epat(16'(a)), "R8 low read after boot off", 32'(d), 32'(epat(16'(a))));
        end
        wr(16'hFF50, 8'hFF, w, e, wa);
        rd(16'h0000, d, w, b, e, wa);
        chk(b === 1'b0 && d === epat(16'h0000), "R8 stays off", 32'(d), 32'(epat(16'h0000)));

        // R2 lower window
        for (int a = 16'hC000; a < 16'hD000; a += 16'h37) begin
            rd(16'(a), d, w, b, e, wa);
            chk(w === 1'b1 && e === 1'b0 && wa === 15'(a & 16'h0FFF) && d === wpat(15'(a & 16'h0FFF)),
                "R2 low window read", 32'(wa), 32'(a & 16'h0FFF));
        end
        wr(16'hCABC, 8'h11, w, e, wa);
        chk(w === 1'b1 && wa === 15'h0ABC && wram_wdata === 8'h11, "R2 low window write", 32'(wa), 32'h0ABC);

        // R3 / R4 upper window under every bank value
        for (int v = 0; v < 8; v++) begin
            eb = (v == 0) ? 3'd1 : 3'(v);
            wr(16'hFF70, {5'b10101, 3'(v)}, w, e, wa);
            chk(e === 1'b0, "R4 bank write not forwarded", 32'(e), 32'd0);
            rd(16'hFF70, d, w, b, e, wa);
            chk(d === {5'b11111, eb}, "R4 bank readback", 32'(d), 32'({5'b11111, eb}));
            for (int a = 16'hD000; a < 16'hE000; a += 16'h1F3) begin
                rd(16'(a), d, w, b, e, wa);
                chk(w === 1'b1 && wa === {eb, 12'(a)} && d === wpat({eb, 12'(a)}),
                    "R3 upper window read", 32'(wa), 32'({eb, 12'(a)}));
            end
            wr(16'hDFFF, 8'h3C, w, e, wa);
            chk(w === 1'b1 && wa === {eb, 12'hFFF}, "R3 upper window write", 32'(wa), 32'({eb, 12'hFFF}));
        end

        // R6 echo window (bank 5 selected, echo must still be bank 0)
        wr(16'hFF70, 8'h05, w, e, wa);
        for (int a = 16'hE000; a < 16'hF000; a += 16'h1A1) begin
            rd(16'(a), d, w, b, e, wa);
            chk(w === 1'b1 && wa === 15'(a & 16'h1FFF) && d === wpat(15'(a & 16'h1FFF)),
                "R6 echo read", 32'(wa), 32'(a & 16'h1FFF));
        end
        wr(16'hE123, 8'h99, w, e, wa);
        chk(w === 1'b1 && e === 1'b0 && wa === 15'h0123, "R6 echo write", 32'(wa), 32'h0123);

        // R9 high RAM
        for (int a = 16'hFF80; a <= 16'hFFFE; a++)
            wr(16'(a), 8'(a & 16'h7F) ^ 8'h3C, w, e, wa);
        for (int a = 16'hFF80; a <= 16'hFFFE; a++) begin
            rd(16'(a), d, w, b, e, wa);
            chk(e === 1'b0 && w === 1'b0 && d === (8'(a & 16'h7F) ^ 8'h3C), "R9 hram readback",
                32'(d), 32'(8'(a & 16'h7F) ^ 8'h3C));
        end

        // R11 both strobes: write wins, no read data
        @(negedge clk);
        cpu_addr = 16'hFF90; cpu_wdata = 8'hE7; cpu_re = 1'b1; cpu_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(rd_valid === 1'b0, "R11 combined strobes give no read", 32'(rd_valid), 32'd0);
        cpu_re = 1'b0; cpu_we = 1'b0;
        rd(16'hFF90, d, w, b, e, wa);
        chk(d === 8'hE7, "R11 combined strobes wrote", 32'(d), 32'hE7);

        // R5 monochrome mode
        wr(16'hFF70, 8'h06, w, e, wa);
        mono_mode = 1'b1;
        rd(16'hD345, d, w, b, e, wa);
        chk(wa === 15'h1345 && d === wpat(15'h1345), "R5 mono upper bank 1", 32'(wa), 32'h1345);
        wr(16'hFF70, 8'h03, w, e, wa);
        wr(16'hD001, 8'h00, w, e, wa);
        chk(w === 1'b1 && wa === 15'h1001, "R5 mono upper write bank 1", 32'(wa), 32'h1001);
        mono_mode = 1'b0;
        rd(16'hFF70, d, w, b, e, wa);
        chk(d === 8'hFE, "R5 mono bank write ignored", 32'(d), 32'hFE);
        rd(16'hD345, d, w, b, e, wa);
        chk(wa === 15'h6345, "R5 colour bank restored", 32'(wa), 32'h6345);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule